// File: doc/BRIEF.md
# Overflow-Triggered Monitor Freeze Controller

This block decides when branch recording and event counting must stop after a monitoring interrupt condition. It watches one overflow pulse per counter, the interrupt-enable setting of each general-purpose and fixed counter, and an almost-full flag from a sample buffer that has reached its threshold. Any of these raises an interrupt request in the same cycle. If the matching freeze bits are set in the debug control register, branch recording and/or counting are frozen from the next clock edge.

A mode input selects one of two freeze styles. In legacy style the hardware clears the software enable bits: the record-enable bit of the debug control register and the whole global counter-enable register. Software must write them back to resume. In streamlined style the control bits are left alone. Instead the hardware sets sticky frozen flags in a status register, and these flags mask the effective enables. Software clears the flags by writing ones to a separate status-reset register. The registers sit behind a simple single-cycle register port with a combinational read.

Register map, 2-bit address: 0 debug control, 1 global counter enable, 2 freeze status (read-only), 3 status reset (write-only, reads zero).

Top module: `mon_freeze_ctl`

## Requirements
- R1: After reset all registers read zero, `lbrEnable` is 0, every `cntEnable` bit is 0, and `irq` is 0 while no freeze source is active.
- R2: Address 0 holds the debug control register. Only bit 0 (record enable), bit 11 (freeze recording on interrupt) and bit 12 (freeze counters on interrupt) are stored; every other bit reads 0. Address 1 holds the global counter-enable register in bits [NUM_GP+NUM_FIX-1:0], general-purpose counters first and then the fixed counters, with the unused bits reading 0. Address 3 always reads 0. With no freeze active, `lbrEnable` follows debug bit 0 and `cntEnable` follows the global enable bits.
- R3: `irq` is high in the same cycle as any of these sources: a general-purpose overflow whose `gpIntEn` bit is set; a fixed overflow whose 4-bit field in `fixCtrl` has bit 3 set (field i occupies bits [4i+3:4i]); or `bufAlmostFull`. An overflow without its enable leaves `irq` low.
- R4: In legacy mode (`modeStreamlined`=0) a freeze source with debug bit 11 set clears debug bit 0 at the next edge, which drops `lbrEnable`. The bit stays clear until software writes it to 1.
- R5: In legacy mode a freeze source with debug bit 12 set clears the entire global counter-enable register at the next edge, which drops all of `cntEnable`.
- R6: In streamlined mode a freeze source with debug bit 11 set sets status bit 0 (recording frozen) and drops `lbrEnable`. Debug bit 0 keeps its value.
- R7: In streamlined mode a freeze source with debug bit 12 set sets status bit 1 (counters frozen) and forces all of `cntEnable` low. The global counter-enable register keeps its value.
- R8: A freeze source while debug bits 11 and 12 are both clear still raises `irq`, but changes no register and no enable output.
- R9: The status flags are sticky. Writing 1 to bit 0 or bit 1 of address 3 clears the matching flag. A hardware set in the same cycle wins over the clear.
- R10: When a software write to address 0 or 1 falls in the same cycle as a legacy hardware clear of that register, the clear wins for the bits it clears. The other written bits of the debug register still take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeStreamlined | input | 1 | 0 legacy freeze style, 1 streamlined |
| gpOvf | input | NUM_GP | Overflow pulse per general-purpose counter |
| gpIntEn | input | NUM_GP | Interrupt enable per general-purpose counter |
| fixOvf | input | NUM_FIX | Overflow pulse per fixed counter |
| fixCtrl | input | 4*NUM_FIX | 4-bit control field per fixed counter, bit 3 enables the interrupt |
| bufAlmostFull | input | 1 | Sample buffer reached its interrupt threshold |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| lbrEnable | output | 1 | Effective branch-record enable |
| cntEnable | output | NUM_GP+NUM_FIX | Effective per-counter count enable |
| irq | output | 1 | Monitoring interrupt request |

## Verification
Two collisions can fall in one cycle. The first is a software register write meeting a legacy hardware clear of the same register. The second is a status-reset write meeting a streamlined hardware set of the same flag. The bench provokes each one by asserting a freeze source in the exact cycle it issues the write. It judges the outcome by reading the register back on the next cycle: the hardware action must win, and the unrelated written bits must still land.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DBG = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_GEN = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLR = 2'd3;

  localparam int DBG_REC     = 0;
  localparam int DBG_FRZ_REC = 11;
  localparam int DBG_FRZ_CNT = 12;
  localparam int FIX_FIELD_W = 4;
  localparam int FIX_PMI_BIT = 3;

  localparam logic [DATA_W-1:0] DBG_MASK =
    (DATA_W'(1) << DBG_REC) | (DATA_W'(1) << DBG_FRZ_REC) | (DATA_W'(1) << DBG_FRZ_CNT);

  typedef struct packed {
    logic wrDbg;
    logic wrGen;
    logic clrBrFlag;
    logic clrCtrFlag;
    logic clrRec;
    logic clrCnt;
    logic setBrFrz;
    logic setCtrFrz;
  } strobes_t;
endpackage

// File: rtl/mfc_ctrl.sv
module mfc_ctrl
  import mfc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3
) (
  input  logic                         modeStreamlined,
  input  logic [NUM_GP-1:0]            gpOvf,
  input  logic [NUM_GP-1:0]            gpIntEn,
  input  logic [NUM_FIX-1:0]           fixOvf,
  input  logic [FIX_FIELD_W*NUM_FIX-1:0] fixCtrl,
  input  logic                         bufAlmostFull,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [1:0]                   wrLow,
  input  logic                         frzRecBit,
  input  logic                         frzCntBit,
  output strobes_t                     st,
  output logic                         irq
);
  logic [NUM_FIX-1:0] fixIntEn;
  logic               freezeEvt;

  for (genvar i = 0; i < NUM_FIX; i++) begin : g_fixDecode
    assign fixIntEn[i] = fixCtrl[i*FIX_FIELD_W + FIX_PMI_BIT];
  end

  assign freezeEvt = (|(gpOvf & gpIntEn)) | (|(fixOvf & fixIntEn)) | bufAlmostFull;
  assign irq = freezeEvt;

  always_comb begin
    st            = '0;
    st.wrDbg      = regWrEn && (regAddr == ADDR_DBG);
    st.wrGen      = regWrEn && (regAddr == ADDR_GEN);
    st.clrBrFlag  = regWrEn && (regAddr == ADDR_CLR) && wrLow[0];
    st.clrCtrFlag = regWrEn && (regAddr == ADDR_CLR) && wrLow[1];
    st.clrRec     = freezeEvt && frzRecBit && !modeStreamlined;
    st.clrCnt     = freezeEvt && frzCntBit && !modeStreamlined;
    st.setBrFrz   = freezeEvt && frzRecBit && modeStreamlined;
    st.setCtrFrz  = freezeEvt && frzCntBit && modeStreamlined;
  end
endmodule

// File: rtl/mfc_datapath.sv
module mfc_datapath
  import mfc_pkg::*;
#(
  parameter int NUM_CNT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               lbrEnable,
  output logic [NUM_CNT-1:0] cntEnable,
  output logic [DATA_W-1:0]  dbgQ,
  output logic [NUM_CNT-1:0] genQ,
  output logic               brFrzQ,
  output logic               ctrFrzQ
);
  logic [DATA_W-1:0]  dbgNext;
  logic [NUM_CNT-1:0] genNext;

  always_comb begin
    dbgNext = dbgQ;
    if (st.wrDbg) dbgNext = wrData & DBG_MASK;
    if (st.clrRec) dbgNext[DBG_REC] = 1'b0;
    genNext = genQ;
    if (st.wrGen) genNext = wrData[NUM_CNT-1:0];
    if (st.clrCnt) genNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgQ    <= '0;
      genQ    <= '0;
      brFrzQ  <= 1'b0;
      ctrFrzQ <= 1'b0;
    end else begin
      dbgQ <= dbgNext;
      genQ <= genNext;
      if (st.setBrFrz) brFrzQ <= 1'b1;
      else if (st.clrBrFlag) brFrzQ <= 1'b0;
      if (st.setCtrFrz) ctrFrzQ <= 1'b1;
      else if (st.clrCtrFlag) ctrFrzQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_DBG: rdData = dbgQ;
      ADDR_GEN: rdData = DATA_W'(genQ);
      ADDR_STS: rdData = DATA_W'({ctrFrzQ, brFrzQ});
      default:  rdData = '0;
    endcase
  end

  assign lbrEnable = dbgQ[DBG_REC] & ~brFrzQ;
  assign cntEnable = genQ & {NUM_CNT{~ctrFrzQ}};
endmodule

// File: rtl/mon_freeze_ctl.sv
module mon_freeze_ctl
  import mfc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int NUM_CNT = NUM_GP + NUM_FIX
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           modeStreamlined,
  input  logic [NUM_GP-1:0]              gpOvf,
  input  logic [NUM_GP-1:0]              gpIntEn,
  input  logic [NUM_FIX-1:0]             fixOvf,
  input  logic [FIX_FIELD_W*NUM_FIX-1:0] fixCtrl,
  input  logic                           bufAlmostFull,
  input  logic                           regWrEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWrData,
  output logic [DATA_W-1:0]              regRdData,
  output logic                           lbrEnable,
  output logic [NUM_CNT-1:0]             cntEnable,
  output logic                           irq
);
  strobes_t           st;
  logic [DATA_W-1:0]  dbgQ;
  logic [NUM_CNT-1:0] genQ;
  logic               brFrzQ;
  logic               ctrFrzQ;

  mfc_ctrl #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_ctrl (
    .modeStreamlined(modeStreamlined),
    .gpOvf(gpOvf),
    .gpIntEn(gpIntEn),
    .fixOvf(fixOvf),
    .fixCtrl(fixCtrl),
    .bufAlmostFull(bufAlmostFull),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .wrLow(regWrData[1:0]),
    .frzRecBit(dbgQ[DBG_FRZ_REC]),
    .frzCntBit(dbgQ[DBG_FRZ_CNT]),
    .st(st),
    .irq(irq)
  );

  mfc_datapath #(.NUM_CNT(NUM_CNT)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .st(st),
    .wrData(regWrData),
    .rdAddr(regAddr),
    .rdData(regRdData),
    .lbrEnable(lbrEnable),
    .cntEnable(cntEnable),
    .dbgQ(dbgQ),
    .genQ(genQ),
    .brFrzQ(brFrzQ),
    .ctrFrzQ(ctrFrzQ)
  );
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker
  import mfc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int NUM_CNT = NUM_GP + NUM_FIX
) (
  input logic               clk,
  input logic               rstN,
  input logic               modeStreamlined,
  input logic [NUM_GP-1:0]  gpOvf,
  input logic [NUM_FIX-1:0] fixOvf,
  input logic               bufAlmostFull,
  input logic               regWrEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [1:0]         wrLow,
  input logic               irq,
  input logic               lbrEnable,
  input logic [NUM_CNT-1:0] cntEnable,
  input logic               dbgRec,
  input logic               dbgFrzRec,
  input logic               dbgFrzCnt,
  input logic [NUM_CNT-1:0] genQ,
  input logic               brFrzQ,
  input logic               ctrFrzQ
);
  // R3: no source, no interrupt
  p_quiet_irq_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gpOvf == '0 && fixOvf == '0 && !bufAlmostFull) |-> !irq);

  // R4: legacy recording freeze drops the record enable
  p_legacy_rec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStreamlined && irq && dbgFrzRec) |=> (!dbgRec && !lbrEnable));

  // R5: legacy counter freeze empties the global enable
  p_legacy_cnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStreamlined && irq && dbgFrzCnt) |=> (genQ == '0 && cntEnable == '0));

  // R6: streamlined recording freeze keeps the debug bit
  p_stream_rec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeStreamlined && irq && dbgFrzRec && !(regWrEn && regAddr == ADDR_DBG))
      |=> (brFrzQ && !lbrEnable && $stable(dbgRec)));

  // R7: streamlined counter freeze keeps the global enable
  p_stream_cnt_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeStreamlined && irq && dbgFrzCnt && !(regWrEn && regAddr == ADDR_GEN))
      |=> (ctrFrzQ && cntEnable == '0 && $stable(genQ)));

  // R9: flags hold unless cleared
  p_sticky_br_r9: assert property (@(posedge clk) disable iff (!rstN)
    (brFrzQ && !(regWrEn && regAddr == ADDR_CLR && wrLow[0])) |=> brFrzQ);
  p_sticky_ctr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrFrzQ && !(regWrEn && regAddr == ADDR_CLR && wrLow[1])) |=> ctrFrzQ);
endmodule

bind mon_freeze_ctl mfc_checker #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .modeStreamlined(modeStreamlined),
  .gpOvf(gpOvf),
  .fixOvf(fixOvf),
  .bufAlmostFull(bufAlmostFull),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .wrLow(regWrData[1:0]),
  .irq(irq),
  .lbrEnable(lbrEnable),
  .cntEnable(cntEnable),
  .dbgRec(dbgQ[0]),
  .dbgFrzRec(dbgQ[11]),
  .dbgFrzCnt(dbgQ[12]),
  .genQ(genQ),
  .brFrzQ(brFrzQ),
  .ctrFrzQ(ctrFrzQ)
);

// File: tb/mon_freeze_ctl_tb.sv
`timescale 1ns/1ps
module mon_freeze_ctl_tb;
  localparam int NG = 4;
  localparam int NF = 3;
  localparam int NC = NG + NF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeStreamlined = 1'b0;
  logic [NG-1:0] gpOvf = '0;
  logic [NG-1:0] gpIntEn = '0;
  logic [NF-1:0] fixOvf = '0;
  logic [4*NF-1:0] fixCtrl = '0;
  logic          bufAlmostFull = 1'b0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          lbrEnable;
  logic [NC-1:0] cntEnable;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  mon_freeze_ctl #(.NUM_GP(NG), .NUM_FIX(NF)) u_dut (
    .clk(clk), .rstN(rstN), .modeStreamlined(modeStreamlined),
    .gpOvf(gpOvf), .gpIntEn(gpIntEn), .fixOvf(fixOvf), .fixCtrl(fixCtrl),
    .bufAlmostFull(bufAlmostFull), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lbrEnable(lbrEnable),
    .cntEnable(cntEnable), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, optional write plus optional freeze source
  task automatic cycle(input logic wr, input logic [1:0] addr, input logic [31:0] data,
                       input logic [NG-1:0] gp, input logic [NF-1:0] fx, input logic af);
    @(negedge clk);
    regWrEn = wr; regAddr = addr; regWrData = data;
    gpOvf = gp; fixOvf = fx; bufAlmostFull = af;
    @(negedge clk);
    regWrEn = 1'b0; gpOvf = '0; fixOvf = '0; bufAlmostFull = 1'b0;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [31:0] data);
    cycle(1'b1, addr, data, '0, '0, 1'b0);
  endtask

  task automatic rd(input logic [1:0] addr, output logic [31:0] data);
    regAddr = addr;
    #1 data = regRdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset();
    logic [31:0] v;
    doReset();
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1", $sformatf("reg%0d after reset", a), v, 0);
    end
    check("R1", "lbrEnable reset", 32'(lbrEnable), 0);
    check("R1", "cntEnable reset", 32'(cntEnable), 0);
    check("R1", "irq reset", 32'(irq), 0);
  endtask

  task automatic tRegAccess();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R2", "debug mask", v, 32'h1801);
    check("R2", "lbrEnable follows bit0", 32'(lbrEnable), 1);
    wr(2'd1, 32'hFFFF_FF55);
    rd(2'd1, v); check("R2", "global enable mask", v, 32'h55);
    check("R2", "cntEnable follows", 32'(cntEnable), 32'h55);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R2", "reset reg reads 0", v, 0);
    wr(2'd2, 32'h3);
    rd(2'd2, v); check("R2", "status read-only", v, 0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  task automatic tSources();
    gpIntEn = 4'b0100;
    fixCtrl = 12'h870;  // field0=0, field1=7 (no bit3), field2=8
    @(negedge clk);
    gpOvf = 4'b0100; #1 check("R3", "gp overflow enabled", 32'(irq), 1);
    gpOvf = 4'b1011; #1 check("R3", "gp overflow not enabled", 32'(irq), 0);
    gpOvf = '0; fixOvf = 3'b100; #1 check("R3", "fixed overflow enabled", 32'(irq), 1);
    fixOvf = 3'b011; #1 check("R3", "fixed overflow not enabled", 32'(irq), 0);
    fixOvf = '0; bufAlmostFull = 1'b1; #1 check("R3", "buffer almost full", 32'(irq), 1);
    bufAlmostFull = 1'b0; #1 check("R3", "quiet", 32'(irq), 0);
    @(negedge clk);
  endtask

  task automatic tNoFreezeBits();
    logic [31:0] v;
    modeStreamlined = 1'b0;
    wr(2'd0, 32'h1); wr(2'd1, 32'h7F);
    cycle(1'b0, 2'd0, 0, '0, '0, 1'b1);
    rd(2'd0, v); check("R8", "debug unchanged", v, 32'h1);
    rd(2'd1, v); check("R8", "global unchanged", v, 32'h7F);
    modeStreamlined = 1'b1;
    cycle(1'b0, 2'd0, 0, 4'b0100, '0, 1'b0);
    rd(2'd2, v); check("R8", "no flags", v, 0);
    check("R8", "outputs live", 32'({lbrEnable, cntEnable}), 32'hFF);
    modeStreamlined = 1'b0;
  endtask

  task automatic tLegacy();
    logic [31:0] v;
    doReset();
    modeStreamlined = 1'b0;
    wr(2'd0, 32'h0801); wr(2'd1, 32'h7F);
    cycle(1'b0, 2'd0, 0, '0, 3'b100, 1'b0);
    rd(2'd0, v); check("R4", "bit0 cleared", v, 32'h0800);
    check("R4", "lbrEnable low", 32'(lbrEnable), 0);
    rd(2'd1, v); check("R4", "global kept", v, 32'h7F);
    cycle(1'b0, 2'd0, 0, '0, '0, 1'b0);
    check("R4", "stays frozen", 32'(lbrEnable), 0);
    wr(2'd0, 32'h1801);
    check("R4", "software resumes", 32'(lbrEnable), 1);
    cycle(1'b0, 2'd0, 0, '0, '0, 1'b1);
    rd(2'd1, v); check("R5", "global cleared", v, 0);
    check("R5", "cntEnable low", 32'(cntEnable), 0);
    rd(2'd2, v); check("R5", "no status flags", v, 0);
    wr(2'd1, 32'h3C);
    check("R5", "software restores", 32'(cntEnable), 32'h3C);
  endtask

  task automatic tCollision();
    logic [31:0] v;
    wr(2'd0, 32'h1801);
    cycle(1'b1, 2'd0, 32'h0001, '0, '0, 1'b1);
    rd(2'd0, v); check("R10", "debug write vs clear", v, 0);
    wr(2'd0, 32'h1000);
    cycle(1'b1, 2'd1, 32'h55, 4'b0100, '0, 1'b0);
    rd(2'd1, v); check("R10", "global write vs clear", v, 0);
    wr(2'd0, 32'h0801);
    cycle(1'b1, 2'd0, 32'h1801, '0, '0, 1'b1);
    rd(2'd0, v); check("R10", "other written bits land", v, 32'h1800);
  endtask

  task automatic tStreamlined();
    logic [31:0] v;
    doReset();
    modeStreamlined = 1'b1;
    wr(2'd0, 32'h0801); wr(2'd1, 32'h7F);
    cycle(1'b0, 2'd0, 0, '0, '0, 1'b1);
    rd(2'd2, v); check("R6", "branch flag set", v, 32'h1);
    rd(2'd0, v); check("R6", "debug kept", v, 32'h0801);
    check("R6", "lbrEnable masked", 32'(lbrEnable), 0);
    check("R6", "counters still on", 32'(cntEnable), 32'h7F);
    wr(2'd0, 32'h1801);
    cycle(1'b0, 2'd0, 0, 4'b0100, '0, 1'b0);
    rd(2'd2, v); check("R7", "both flags", v, 32'h3);
    rd(2'd1, v); check("R7", "global kept", v, 32'h7F);
    check("R7", "cntEnable masked", 32'(cntEnable), 0);
  endtask

  task automatic tClear();
    logic [31:0] v;
    cycle(1'b1, 2'd3, 32'h3, '0, '0, 1'b1);
    rd(2'd2, v); check("R9", "set beats clear", v, 32'h3);
    cycle(1'b0, 2'd0, 0, '0, '0, 1'b0);
    rd(2'd2, v); check("R9", "sticky", v, 32'h3);
    wr(2'd3, 32'h2);
    rd(2'd2, v); check("R9", "clear counter flag only", v, 32'h1);
    check("R9", "counters resume", 32'(cntEnable), 32'h7F);
    wr(2'd3, 32'h1);
    rd(2'd2, v); check("R9", "clear branch flag", v, 0);
    check("R9", "recording resumes", 32'(lbrEnable), 1);
  endtask

  initial begin
    tReset();
    tRegAccess();
    tSources();
    tNoFreezeBits();
    tLegacy();
    tCollision();
    tStreamlined();
    tClear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule